// File: doc/BRIEF.md
# Periodic Battery Health Checker

This block watches a backup battery by testing it at a fixed cadence instead of tracking a comparator continuously. Once the system supervisor lets go of its reset, an interval counter starts. The last few cycles of every interval form a measurement window. During the window the block raises a load-enable output, which switches in the divider load so the battery is tested under load. At the close of the window it takes one strobed sample of a digital "battery above threshold" flag.

A low sample pulls the battery-good status down, and it stays down. A good sample leaves the status as it is. Only the power-on clear returns the status to good. The comparator flag comes from the analog domain and passes through a two-flop synchroniser first. The interval length and the window length are cycle-count parameters. The defaults are 200 ms and 25 µs at a 250 MHz clock.

Top module: `batt_health_chk`

## Requirements
- R1: While `rst_ni` is low, `batt_ok_o` is 1 and `meas_en_o` is 0. Both values also hold in the first cycle after `rst_ni` is released.
- R2: Each measurement window holds `meas_en_o` at 1 for exactly `WINDOW_CYC` consecutive cycles.
- R3: Count as edge 1 the first rising clock edge at which `sys_rst_ni` is seen high. Then `meas_en_o` is 1 after edges k where (k mod `PERIOD_CYC`) lies in [`PERIOD_CYC`-`WINDOW_CYC`, `PERIOD_CYC`-1], and it is 0 after every other edge. The first check therefore lands one full interval after release.
- R4: In every cycle that follows a rising edge at which `sys_rst_ni` is low, `meas_en_o` is 0. Such an edge restarts the interval count and cancels any check due at that edge. `batt_ok_o` keeps its level.
- R5: The sample is taken at edge k with k mod `PERIOD_CYC` = 0, which ends the window. If the synchronised flag is 0 there, `batt_ok_o` goes from 1 to 0 in the same cycle that `meas_en_o` falls.
- R6: If the synchronised flag is 1 at the sample, `batt_ok_o` keeps its level. A 0 on `batt_ok_o` stays until the next power-on clear, and `sys_rst_ni` does not restore it.
- R7: `bat_above_i` has no effect outside the sampling edge. A low level before the window, or early in the window, does not change `batt_ok_o`.
- R8: `bat_above_i` passes through two flops. The value used at sample edge k is the value present at edge k-2. A low that first appears at edge k-1 or at edge k is not seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on clear, active low |
| sys_rst_ni | input | 1 | System reset from the supervisor, active low, synchronous to clk_i |
| bat_above_i | input | 1 | Asynchronous comparator flag, 1 = battery above threshold |
| meas_en_o | output | 1 | Divider load enable, high during the measurement window |
| batt_ok_o | output | 1 | Battery good status |

## Verification
Two functions can meet in one cycle: the end-of-window sample and a reassertion of the supervisor reset. The bench runs an interval with the battery flag low. It then drops `sys_rst_ni` in the last window cycle, so that the sampling edge and the reset arrive together. The check expects `batt_ok_o` to stay high, because the reset cancels the check. A second collision comes from the synchroniser latency: a low that first appears one edge or zero edges before the sample must be missed, while a low present at edge k-2 must be caught. The bench places single-cycle lows at exactly those edges.

// File: rtl/bhc_pkg.sv
package bhc_pkg;
  typedef enum logic [1:0] {
    PH_HOLD = 2'd0,
    PH_WAIT = 2'd1,
    PH_MEAS = 2'd2
  } phase_e;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/bhc_sync.sv
module bhc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= RST_VAL;
        else         sr_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/bhc_sched.sv
module bhc_sched
  import bhc_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 50_000_000,
  parameter int unsigned WINDOW_CYC = 6250
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   run_i,
  output phase_e phase_o,
  output logic   strobe_o
);
  localparam int unsigned CW   = cnt_w(PERIOD_CYC);
  localparam int unsigned LO_I = PERIOD_CYC - WINDOW_CYC;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);
  localparam logic [CW-1:0] LO   = CW'(LO_I);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= run_i;
      if (!run_i || cnt_q == LAST) cnt_q <= '0;
      else                         cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (!run_q)          phase_o = PH_HOLD;
    else if (cnt_q >= LO) phase_o = PH_MEAS;
    else                 phase_o = PH_WAIT;
  end

  // sample on the last window cycle; a reset at that edge cancels it
  assign strobe_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/bhc_status.sv
module bhc_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic above_i,
  output logic ok_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                  ok_o <= 1'b1;
    else if (strobe_i && !above_i) ok_o <= 1'b0;
endmodule

// File: rtl/batt_health_chk.sv
module batt_health_chk
  import bhc_pkg::*;
#(
  parameter int unsigned PERIOD_CYC  = 50_000_000,
  parameter int unsigned WINDOW_CYC  = 6250,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_rst_ni,
  input  logic bat_above_i,
  output logic meas_en_o,
  output logic batt_ok_o
);
  phase_e phase;
  logic   strobe;
  logic   above_s;

  bhc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (bat_above_i),
    .q_o   (above_s)
  );

  bhc_sched #(.PERIOD_CYC(PERIOD_CYC), .WINDOW_CYC(WINDOW_CYC)) u_sched (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (sys_rst_ni),
    .phase_o (phase),
    .strobe_o(strobe)
  );

  bhc_status u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe),
    .above_i (above_s),
    .ok_o    (batt_ok_o)
  );

  assign meas_en_o = (phase == PH_MEAS);
endmodule

// File: rtl/bhc_chk.sv
module bhc_chk #(
  parameter int unsigned PERIOD_CYC = 50_000_000,
  parameter int unsigned WINDOW_CYC = 6250
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sys_rst_ni,
  input logic meas_en_o,
  input logic batt_ok_o
);
  logic [31:0] win_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        win_cnt_q <= '0;
    else if (meas_en_o) win_cnt_q <= (win_cnt_q == 32'hFFFF_FFFF) ? win_cnt_q : win_cnt_q + 1;
    else                win_cnt_q <= '0;

  p_win_max_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_en_o |-> (win_cnt_q < 32'(WINDOW_CYC)));

  p_win_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(meas_en_o) && $past(sys_rst_ni)) |-> (win_cnt_q == 32'(WINDOW_CYC)));

  p_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_ni |=> !meas_en_o);

  p_fall_at_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(batt_ok_o) |-> $fell(meas_en_o));

  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !batt_ok_o |=> !batt_ok_o);

  p_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !meas_en_o |=> $stable(batt_ok_o));
endmodule

bind batt_health_chk bhc_chk #(.PERIOD_CYC(PERIOD_CYC), .WINDOW_CYC(WINDOW_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sys_rst_ni(sys_rst_ni),
  .meas_en_o (meas_en_o),
  .batt_ok_o (batt_ok_o)
);

// File: tb/batt_health_chk_tb.sv
module batt_health_chk_tb;
  localparam int P = 20;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sys_rst_ni = 1'b0;
  logic bat_above = 1'b1;
  logic meas_en, batt_ok;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  batt_health_chk #(.PERIOD_CYC(P), .WINDOW_CYC(W), .SYNC_STAGES(2)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .sys_rst_ni (sys_rst_ni),
    .bat_above_i(bat_above),
    .meas_en_o  (meas_en),
    .batt_ok_o  (batt_ok)
  );

  typedef struct packed {
    logic por;
    int   lf;
    int   lt;
    logic ok;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b1, 0,     0,       1'b1},  // R3 all high
    '{1'b0, 1,     P-W-3,   1'b1},  // R7 low before window
    '{1'b0, P-1,   P,       1'b1},  // R8 too late to be seen
    '{1'b0, P-W,   P-3,     1'b1},  // R7 low early in window
    '{1'b0, 1,     P,       1'b0},  // R5 low at sample
    '{1'b0, 0,     0,       1'b0},  // R6 stays low
    '{1'b1, 0,     0,       1'b1},  // R1 power-on clear restores
    '{1'b0, P-2,   P-2,     1'b0}   // R8 low exactly at edge k-2
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic b);
    bat_above = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic por();
    rst_ni = 1'b0;
    sys_rst_ni = 1'b0;
    bat_above = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 batt_ok in clear", batt_ok, 1);
    chk("R1 meas_en in clear", meas_en, 0);
    rst_ni = 1'b1;
    step(1'b1);
    chk("R1 batt_ok after clear", batt_ok, 1);
  endtask

  // starts at a negedge; next posedge is edge 1 of the interval
  task automatic run_interval(input int lf, input int lt, input logic exp_ok, input string tag);
    int bad;
    logic ok_before;
    bad = 0;
    ok_before = batt_ok;
    for (int k = 1; k <= P; k++) begin
      step((k >= lf && k <= lt) ? 1'b0 : 1'b1);
      if (meas_en != ((k >= P-W && k <= P-1) ? 1'b1 : 1'b0)) bad++;
      if (k == P-1) chk({tag, " R7 no change before sample"}, batt_ok, ok_before);
    end
    chk({tag, " R2/R3 window placement mismatches"}, bad, 0);
    chk({tag, " R5/R6 batt_ok after sample"}, batt_ok, exp_ok);
  endtask

  initial begin
    int bad;
    for (int i = 0; i < 8; i++) begin
      if (TBL[i].por) begin
        por();
        sys_rst_ni = 1'b1;
      end
      run_interval(TBL[i].lf, TBL[i].lt, TBL[i].ok, $sformatf("vec%0d", i));
    end

    // R4: held in system reset, no checks
    por();
    bad = 0;
    for (int k = 0; k < 2*P; k++) begin
      step(1'b0);
      if (meas_en) bad++;
    end
    chk("R4 meas_en while held", bad, 0);
    chk("R4 batt_ok while held", batt_ok, 1);

    // R4: abort inside the window
    sys_rst_ni = 1'b1;
    for (int k = 1; k <= P-2; k++) step(1'b1);
    chk("R4 window open before abort", meas_en, 1);
    sys_rst_ni = 1'b0;
    step(1'b0);
    chk("R4 meas_en drops after abort", meas_en, 0);
    repeat (5) step(1'b0);
    chk("R4 no check after abort", batt_ok, 1);

    // R3: full interval again after re-release
    sys_rst_ni = 1'b1;
    run_interval(0, 0, 1'b1, "restart");

    // R4: reset lands on the sampling edge, battery low
    for (int k = 1; k <= P-1; k++) step(1'b0);
    sys_rst_ni = 1'b0;
    step(1'b0);
    chk("R4 sample cancelled by reset", batt_ok, 1);
    chk("R4 meas_en low after collision", meas_en, 0);

    // R6: system reset does not restore a low status
    sys_rst_ni = 1'b1;
    run_interval(1, P, 1'b0, "drop");
    sys_rst_ni = 1'b0;
    repeat (4) step(1'b1);
    chk("R6 sys reset keeps low", batt_ok, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule